// File: doc/BRIEF.md
# Debug Interface Reset and Ownership Controller

This block decides when the on-chip trace and debug logic behind a JTAG TAP is held in reset, and whether that logic owns the TAP. It runs in the test-clock domain. The debug reset comes from three sources: power-on reset, the compliance-enable pin and the TAP's test-logic-reset state. System reset plays no part in it. After power-on, release also waits for the system PLL to report lock. A bypass strap lifts that wait, so the block can leave reset as soon as power-on reset negates.

TAP ownership is granted when the matching client-enable instruction is decoded while the compliance-enable pin is high. Ownership is lost in the same instant that the debug reset asserts. The block also drives the 12 auxiliary message data pads. While in reset, bit 0 of these pads carries the synchronized clock-locked status and all other bits are driven low. Out of reset, the pads carry the trace data.

Top module: `dbg_rst_ctrl`

## Requirements
- R1: `dbg_rst_o` is high whenever `rst_ni` is low or `tap_tlr_i` is high. No clock edge is needed for this.
- R2: `dbg_rst_o` is high whenever `jcomp_i` is low, and this does not wait for a clock edge.
- R3: When `pll_bypass_i` is low, `dbg_rst_o` stays high after `rst_ni` rises. It releases after the second rising `clk_i` edge that samples `pll_lock_i` high. After only the first such edge it is still high.
- R4: When `pll_bypass_i` is high, `dbg_rst_o` releases without any clock edge once `rst_ni` and `jcomp_i` are high and `tap_tlr_i` is low, whatever the lock state.
- R5: `tap_own_o` rises after the first `clk_i` edge that samples `client_en_i` and `jcomp_i` high with `dbg_rst_o` low. It then stays high after `client_en_i` drops.
- R6: `client_en_i` has no effect while `dbg_rst_o` is high. If it is pulsed only during reset, `tap_own_o` stays low after release.
- R7: `tap_own_o` is never high while `dbg_rst_o` is high. It drops in the same instant the debug reset asserts and stays low until a new grant.
- R8: `tdo_oe_o` is high only when both `tap_own_o` and `tdo_req_i` are high.
- R9: `aux_act_o` is high exactly when `dbg_rst_o` is low.
- R10: While `dbg_rst_o` is high, `mdo_o[11:1]` is 0 and `mdo_o[0]` shows the synchronized lock status. When `dbg_rst_o` is low, `mdo_o` equals `msg_data_i`.
- R11: Low `rst_ni` clears the lock synchronizer. After a new power-on reset, `mdo_o[0]` reads 0 until lock has been sampled on two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| jcomp_i | input | 1 | Compliance-enable pin, active high |
| tap_tlr_i | input | 1 | TAP is in test-logic-reset |
| client_en_i | input | 1 | Debug client-enable instruction decoded |
| tdo_req_i | input | 1 | Client requests to drive TDO |
| pll_lock_i | input | 1 | PLL lock, asynchronous |
| pll_bypass_i | input | 1 | PLL bypass strap |
| msg_data_i | input | 12 | Trace message data for the pads |
| dbg_rst_o | output | 1 | Debug logic reset, active high |
| tap_own_o | output | 1 | TAP ownership grant |
| tdo_oe_o | output | 1 | TDO output enable |
| aux_act_o | output | 1 | Auxiliary port in use |
| mdo_o | output | 12 | Auxiliary message data pad drive |

## Verification
The reset, ownership-drop, TDO-enable, port-use and pad results are combinational. The bench checks them one time unit after changing an input, with no clock edge in between. The ownership grant is due after one rising edge. Reset release on lock, and the lock bit on the pads, are due only after the second rising edge. For these, the bench also samples after the first edge to confirm the value has not yet changed. Inputs change on falling edges, and samples are taken either just after an input change or between edges.

// File: rtl/dbg_rst_pkg.sv
package dbg_rst_pkg;
  parameter int unsigned MDO_W       = 12;
  parameter int unsigned SYNC_STAGES = 2;
  parameter int unsigned LOCK_BIT    = 0;
endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[i] <= 1'b0;
        else if (i == 0) sr_q[i] <= d_i;
        else sr_q[i] <= sr_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = sr_q[LAST];
endmodule

// File: rtl/dbg_rst_gen.sv
module dbg_rst_gen (
  input  logic rst_ni,
  input  logic jcomp_i,
  input  logic tap_tlr_i,
  input  logic lock_sync_i,
  input  logic pll_bypass_i,
  output logic dbg_rst_o
);
  logic clk_ok;
  assign clk_ok    = lock_sync_i | pll_bypass_i;
  // system reset deliberately not an input
  assign dbg_rst_o = ~rst_ni | ~jcomp_i | tap_tlr_i | ~clk_ok;
endmodule

// File: rtl/dbg_own.sv
module dbg_own (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dbg_rst_i,
  input  logic jcomp_i,
  input  logic client_en_i,
  input  logic tdo_req_i,
  output logic own_o,
  output logic tdo_oe_o
);
  logic own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      own_q <= 1'b0;
    else if (dbg_rst_i)               own_q <= 1'b0;
    else if (client_en_i && jcomp_i)  own_q <= 1'b1;
  end

  // gate so ownership drops the instant reset asserts
  assign own_o    = own_q & ~dbg_rst_i;
  assign tdo_oe_o = own_o & tdo_req_i;
endmodule

// File: rtl/dbg_mdo_mux.sv
module dbg_mdo_mux #(
  parameter int unsigned W        = 12,
  parameter int unsigned LOCK_BIT = 0
) (
  input  logic         dbg_rst_i,
  input  logic         lock_i,
  input  logic [W-1:0] msg_i,
  output logic [W-1:0] mdo_o
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pad
      if (i == LOCK_BIT) begin : g_lock
        assign mdo_o[i] = dbg_rst_i ? lock_i : msg_i[i];
      end else begin : g_data
        assign mdo_o[i] = dbg_rst_i ? 1'b0 : msg_i[i];
      end
    end
  endgenerate
endmodule

// File: rtl/dbg_rst_ctrl.sv
module dbg_rst_ctrl
  import dbg_rst_pkg::*;
#(
  parameter int unsigned W      = MDO_W,
  parameter int unsigned STAGES = SYNC_STAGES,
  parameter int unsigned LBIT   = LOCK_BIT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         jcomp_i,
  input  logic         tap_tlr_i,
  input  logic         client_en_i,
  input  logic         tdo_req_i,
  input  logic         pll_lock_i,
  input  logic         pll_bypass_i,
  input  logic [W-1:0] msg_data_i,
  output logic         dbg_rst_o,
  output logic         tap_own_o,
  output logic         tdo_oe_o,
  output logic         aux_act_o,
  output logic [W-1:0] mdo_o
);
  logic lock_sync;
  logic dbg_rst;

  dbg_sync #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (pll_lock_i), .q_o (lock_sync)
  );

  dbg_rst_gen u_rst (
    .rst_ni (rst_ni), .jcomp_i (jcomp_i), .tap_tlr_i (tap_tlr_i),
    .lock_sync_i (lock_sync), .pll_bypass_i (pll_bypass_i), .dbg_rst_o (dbg_rst)
  );

  dbg_own u_own (
    .clk_i (clk_i), .rst_ni (rst_ni), .dbg_rst_i (dbg_rst), .jcomp_i (jcomp_i),
    .client_en_i (client_en_i), .tdo_req_i (tdo_req_i),
    .own_o (tap_own_o), .tdo_oe_o (tdo_oe_o)
  );

  dbg_mdo_mux #(.W(W), .LOCK_BIT(LBIT)) u_mux (
    .dbg_rst_i (dbg_rst), .lock_i (lock_sync), .msg_i (msg_data_i), .mdo_o (mdo_o)
  );

  assign dbg_rst_o = dbg_rst;
  assign aux_act_o = ~dbg_rst;
endmodule

// File: rtl/dbg_rst_ctrl_chk.sv
module dbg_rst_ctrl_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         jcomp_i,
  input logic         tap_tlr_i,
  input logic         client_en_i,
  input logic         dbg_rst_o,
  input logic         tap_own_o,
  input logic         tdo_oe_o,
  input logic         aux_act_o,
  input logic [W-1:0] mdo_o
);
  a_r1_tlr_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_tlr_i |-> dbg_rst_o);
  a_r2_jcomp_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jcomp_i |-> dbg_rst_o);
  a_r5_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (client_en_i && jcomp_i && !dbg_rst_o) |=> (tap_own_o || dbg_rst_o));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_own_o |=> (tap_own_o || dbg_rst_o));
  a_r7_no_own_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_rst_o |-> !tap_own_o);
  a_r7_drop_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tap_own_o) |-> dbg_rst_o);
  a_r8_tdo_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdo_oe_o |-> tap_own_o);
  a_r10_pads_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux_act_o |-> (mdo_o[W-1:1] == '0));
endmodule

bind dbg_rst_ctrl dbg_rst_ctrl_chk #(.W(W)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .jcomp_i (jcomp_i), .tap_tlr_i (tap_tlr_i),
  .client_en_i (client_en_i), .dbg_rst_o (dbg_rst_o), .tap_own_o (tap_own_o),
  .tdo_oe_o (tdo_oe_o), .aux_act_o (aux_act_o), .mdo_o (mdo_o)
);

// File: tb/sim_dbg_rst_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_rst_ctrl;
  logic clk = 1'b0;
  logic rst_n, jcomp, tlr, cen, treq, lock, byp;
  logic [11:0] msg;
  logic dbg_rst, own, tdo_oe, aux;
  logic [11:0] mdo;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dbg_rst_ctrl u0 (
    .clk_i (clk), .rst_ni (rst_n), .jcomp_i (jcomp), .tap_tlr_i (tlr),
    .client_en_i (cen), .tdo_req_i (treq), .pll_lock_i (lock), .pll_bypass_i (byp),
    .msg_data_i (msg), .dbg_rst_o (dbg_rst), .tap_own_o (own), .tdo_oe_o (tdo_oe),
    .aux_act_o (aux), .mdo_o (mdo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0; jcomp = 1; tlr = 0; cen = 0; treq = 1; lock = 1; byp = 0; msg = 12'hA5C;
    edges(3);
    chk("R1 rst", dbg_rst, 1);
    chk("R7 own", own, 0);
    chk("R8 tdo", tdo_oe, 0);
    chk("R9 aux", aux, 0);
    chk("R11 mdo", mdo, 0);
  endtask

  task automatic t_lock;
    lock = 0; rst_n = 1; edges(4);
    chk("R3 nolock", dbg_rst, 1);
    chk("R10 mdo0", mdo, 0);
    lock = 1; edges(1);
    chk("R3 one edge", dbg_rst, 1);
    chk("R10 one edge", mdo, 0);
    edges(1);
    chk("R3 release", dbg_rst, 0);
    chk("R9 aux on", aux, 1);
    chk("R10 data", mdo, 12'hA5C);
  endtask

  task automatic t_own;
    treq = 0; cen = 1; #1;
    chk("R5 not yet", own, 0);
    edges(1);
    chk("R5 grant", own, 1);
    cen = 0; edges(3);
    chk("R5 hold", own, 1);
    chk("R8 no req", tdo_oe, 0);
    treq = 1; #1;
    chk("R8 oe", tdo_oe, 1);
  endtask

  task automatic t_tlr;
    @(negedge clk); tlr = 1; #1;
    chk("R1 tlr", dbg_rst, 1);
    chk("R7 drop", own, 0);
    chk("R8 off", tdo_oe, 0);
    chk("R10 lockbit", mdo, 12'h001);
    edges(1); tlr = 0; edges(3);
    chk("R7 stays low", own, 0);
    chk("R10 data back", mdo, 12'hA5C);
  endtask

  task automatic t_ignore;
    @(negedge clk); tlr = 1; cen = 1; edges(3);
    chk("R6 in rst", own, 0);
    cen = 0; edges(1); tlr = 0; edges(3);
    chk("R6 ignored", own, 0);
  endtask

  task automatic t_jcomp;
    cen = 1; edges(1); cen = 0;
    chk("R5 regrant", own, 1);
    jcomp = 0; #1;
    chk("R2 rst", dbg_rst, 1);
    chk("R2 own", own, 0);
    chk("R9 aux off", aux, 0);
    cen = 1; edges(2); cen = 0; jcomp = 1; #1;
    chk("R2 release", dbg_rst, 0);
    chk("R6 jcomp low", own, 0);
  endtask

  task automatic t_resync;
    @(negedge clk); rst_n = 0; edges(2);
    rst_n = 1; #1;
    chk("R11 cleared", mdo, 0);
    edges(1);
    chk("R11 one edge", mdo, 0);
    edges(1);
    chk("R11 release", dbg_rst, 0);
  endtask

  task automatic t_bypass;
    @(negedge clk); rst_n = 0; lock = 0; byp = 1; edges(2);
    chk("R1 por", dbg_rst, 1);
    rst_n = 1; #1;
    chk("R4 immediate", dbg_rst, 0);
    chk("R10 bypass data", mdo, 12'hA5C);
    msg = 12'h3F0; #1;
    chk("R10 follow", mdo, 12'h3F0);
    byp = 0; #1;
    chk("R3 no lock", dbg_rst, 1);
    chk("R10 lock0", mdo, 0);
  endtask

  initial begin
    t_reset;
    t_lock;
    t_own;
    t_tlr;
    t_ignore;
    t_jcomp;
    t_resync;
    t_bypass;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule